// File: doc/BRIEF.md
# Triggered Coarse Delay Generator

This block turns a fast, free-running external trigger train into a slow, precisely delayed timing pulse. The trigger is asynchronous to the block clock. It first passes a synchronizer and a rising-edge detector. An integrated divider then selects one trigger in every N. For example, with an 80 MHz trigger and a ratio of 8000, one trigger in 8000 is selected, which gives a 10 kHz output rate.

Each selected trigger that arrives while the block is idle starts a coarse delay. The delay is counted in whole clock cycles, so one step is 10 ns at 100 MHz. The counter is built from 5-bit segments that pass registered carries. When the programmed count completes, the block raises two outputs: a delayed output level, and an enable for the downstream analog fine-delay stage. Both are held for a programmable number of cycles. The block then returns to idle and waits for the next selected trigger.

The delay must fit inside one divided trigger period, so settings above the limit are clamped. Any trigger that is selected while a delay or pulse is still in flight is dropped. The delay, width and ratio settings are captured only while the block is idle.

Top module: `trig_delay_gen`

## Requirements
- R1: After reset the block is idle, `delay_out` and `fine_en` are low, and the divider count is zero, so the first selected trigger is the N-th enabled trigger edge after reset.
- R2: Each low-to-high transition of `trig_in` produces exactly one internal trigger event, however long the input stays high.
- R3: A trigger edge seen while `trig_en` is low has no effect: it starts no delay and does not advance the divider.
- R4: With `div_cfg` = N, every N-th enabled trigger edge is selected. A value of 0 behaves as 1.
- R5: For an accepted trigger with effective delay D, `delay_out` and `fine_en` rise at the (D+3)-th rising clock edge counted from the first edge at which `trig_in` is high. The three fixed cycles are two synchronizer stages and one arming cycle.
- R6: `delay_cfg` = 0 gives D = 1, and any value above MAX_DELAY (10000 cycles by default) gives D = MAX_DELAY.
- R7: The segmented counter advances by exactly one per cycle across every segment boundary, so delays of 31, 32, 33, 1023, 1024 and 1025 cycles are all exact.
- R8: The outputs stay high for exactly W cycles, where W = `width_cfg`, with 0 treated as 1. The block then returns to idle.
- R9: `fine_en` and `delay_out` are high in exactly the same cycles.
- R10: A trigger selected while a delay or pulse is in progress is dropped and does not disturb the running delay. It still advances the divider count.
- R11: A change to `delay_cfg`, `width_cfg` or `div_cfg` while busy does not affect the run in progress. It applies from the next idle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (100 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Asynchronous external trigger |
| trig_en | input | 1 | Trigger acceptance enable |
| delay_cfg | input | 15 | Coarse delay in clock cycles |
| div_cfg | input | 14 | Trigger division ratio N |
| width_cfg | input | 8 | Output pulse width in cycles |
| fine_en | output | 1 | Enable handoff to the fine-delay stage |
| delay_out | output | 1 | Delayed output level |

## Verification
Single isolated triggers with delays placed on and around the 32 and 1024 segment boundaries show whether the carry pipeline is compensated exactly. Short delays and the clamp values show the fixed arming latency and the limit handling. Bursts of N triggers and triggers with the enable low show whether the divider counts only enabled edges and selects the right one. Triggers injected during counting or during the pulse, held-high triggers, and mid-run configuration writes show that the block rejects events and ignores writes while busy. Random delays, widths and ratios then cover general combinations.

// File: rtl/trig_delay_pkg.sv
// Shared types for the triggered coarse delay generator.
package trig_delay_pkg;
    // Control states: waiting, counting the coarse delay, driving the pulse.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2
    } dly_state_e;
endpackage

// File: rtl/trig_sync_edge.sv
// Synchronizes an asynchronous level into clk and flags its rising edges.
// Assumes the input stays high and stays low for at least two clock cycles each.
// Latency: STAGES cycles to the flag.
module trig_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    // Shift the raw input through the synchronizer chain plus one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/trig_divider.sv
// Selects every ratio_i-th enabled trigger edge.
// Assumes ratio_i >= 1. The count advances on every enabled edge, busy or not.
module trig_divider #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             en_i,
    input  logic [DIV_W-1:0] ratio_i,
    output logic             sel_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             last;

    assign last  = (cnt_q >= ratio_i - DIV_W'(1));
    assign sel_o = edge_i & en_i & last;

    // Count enabled edges and wrap on the selected one.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (edge_i && en_i) cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/seg_delay_counter.sv
// Binary up-counter built from NUM_SEG segments of SEG_W bits.
// The carry into each upper segment is registered one cycle ahead, so the
// combined value is an exact binary count every cycle.
// clr_i has priority over inc_i.
module seg_delay_counter #(
    parameter int SEG_W   = 5,
    parameter int NUM_SEG = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     inc_i,
    output logic [SEG_W*NUM_SEG-1:0] count_o
);
    localparam int CNT_W = SEG_W * NUM_SEG;
    localparam logic [SEG_W-1:0] SEG_TOP = {SEG_W{1'b1}};

    logic [CNT_W-1:0]   cnt_flat;
    logic [NUM_SEG-1:0] mid_full;   // segments 1..i-1 all at top value
    logic               low_near;   // lowest segment one below its top value

    assign low_near = (cnt_flat[SEG_W-1:0] == SEG_TOP - SEG_W'(1));
    assign count_o  = cnt_flat;

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        logic [SEG_W-1:0] q;
        assign cnt_flat[i*SEG_W +: SEG_W] = q;

        if (i == 0) begin : g_low
            assign mid_full[i] = 1'b1;
            // Lowest segment steps on every enabled cycle.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) q <= '0;
                else if (inc_i)      q <= q + SEG_W'(1);
            end
        end else begin : g_up
            logic c_q;
            if (i == 1) begin : g_first
                assign mid_full[i] = 1'b1;
            end else begin : g_chain
                assign mid_full[i] = mid_full[i-1] & (cnt_flat[(i-1)*SEG_W +: SEG_W] == SEG_TOP);
            end
            // Carry is registered one cycle before the lower segments wrap.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) c_q <= 1'b0;
                else                 c_q <= inc_i & low_near & mid_full[i];
            end
            // Upper segment steps when its registered carry arrives.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i)  q <= '0;
                else if (inc_i && c_q) q <= q + SEG_W'(1);
            end
        end
    end
endmodule

// File: rtl/trig_delay_gen.sv
// Triggered coarse delay generator: synchronize, divide, count, pulse.
// Assumes trig_in is asynchronous with high and low phases of two or more cycles.
// Settings are captured only while idle; selected triggers are dropped when busy.
module trig_delay_gen
    import trig_delay_pkg::*;
#(
    parameter int SEG_W       = 5,
    parameter int NUM_SEG     = 3,
    parameter int MAX_DELAY   = 10000,
    parameter int DIV_W       = 14,
    parameter int PW_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trig_in,
    input  logic                     trig_en,
    input  logic [SEG_W*NUM_SEG-1:0] delay_cfg,
    input  logic [DIV_W-1:0]         div_cfg,
    input  logic [PW_W-1:0]          width_cfg,
    output logic                     fine_en,
    output logic                     delay_out
);
    localparam int CNT_W = SEG_W * NUM_SEG;
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_DELAY);

    dly_state_e       st_q;
    logic             acc;
    logic             sel;
    logic             fire;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] d_lat, d_next;
    logic [PW_W-1:0]  w_lat, w_next, wcnt_q;
    logic [DIV_W-1:0] r_lat, r_next;
    logic             out_q, fen_q;

    trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(trig_in), .rise_o(acc)
    );

    trig_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .edge_i(acc), .en_i(trig_en),
        .ratio_i(r_lat), .sel_o(sel)
    );

    seg_delay_counter #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(st_q == ST_IDLE),
        .inc_i(st_q == ST_COUNT), .count_o(cnt)
    );

    assign fire = sel && (st_q == ST_IDLE);

    // Clamp the requested settings to their legal ranges.
    always_comb begin
        if (delay_cfg == '0)       d_next = CNT_W'(1);
        else if (delay_cfg > MAX_C) d_next = MAX_C;
        else                        d_next = delay_cfg;
        w_next = (width_cfg == '0) ? PW_W'(1) : width_cfg;
        r_next = (div_cfg == '0) ? DIV_W'(1) : div_cfg;
    end

    // Capture the settings only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_lat <= CNT_W'(1);
            w_lat <= PW_W'(1);
            r_lat <= DIV_W'(1);
        end else if (st_q == ST_IDLE) begin
            d_lat <= d_next;
            w_lat <= w_next;
            r_lat <= r_next;
        end
    end

    // Sequence: arm on a selected trigger, count the delay, then hold the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            wcnt_q <= '0;
            out_q  <= 1'b0;
            fen_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (fire) st_q <= ST_COUNT;
                end
                ST_COUNT: begin
                    if (cnt == d_lat - CNT_W'(1)) begin
                        st_q   <= ST_PULSE;
                        wcnt_q <= '0;
                        out_q  <= 1'b1;
                        fen_q  <= 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (wcnt_q == w_lat - PW_W'(1)) begin
                        st_q  <= ST_IDLE;
                        out_q <= 1'b0;
                        fen_q <= 1'b0;
                    end else begin
                        wcnt_q <= wcnt_q + PW_W'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign delay_out = out_q;
    assign fine_en   = fen_q;
endmodule

// File: rtl/trig_delay_gen_chk.sv
// Property checker for trig_delay_gen, attached by bind.
module trig_delay_gen_chk
    import trig_delay_pkg::*;
#(
    parameter int CNT_W     = 15,
    parameter int PW_W      = 8,
    parameter int MAX_DELAY = 10000
) (
    input logic             clk,
    input logic             rst_n,
    input dly_state_e       st_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] d_lat_i,
    input logic [PW_W-1:0]  w_lat_i,
    input logic             sel_i,
    input logic             acc_i,
    input logic             out_i,
    input logic             fen_i
);
    logic [PW_W:0] hi_q;

    // Track how many cycles the output has already been high.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (out_i) hi_q <= hi_q + 1'b1;
        else            hi_q <= '0;
    end

    AST_ACC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) acc_i |=> !acc_i); // R2
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (st_i == ST_COUNT) |-> (cnt_i < d_lat_i)); // R5
    AST_DELAY_CLAMP: assert property (@(posedge clk) disable iff (!rst_n) (d_lat_i != '0) && (d_lat_i <= CNT_W'(MAX_DELAY))); // R6
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (st_i == ST_COUNT && $past(st_i) == ST_COUNT) |-> (cnt_i == CNT_W'($past(cnt_i) + 1'b1))); // R7
    AST_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) out_i |-> (hi_q < {1'b0, w_lat_i})); // R8
    AST_OUT_STATE: assert property (@(posedge clk) disable iff (!rst_n) out_i == (st_i == ST_PULSE)); // R8
    AST_FINE_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n) fen_i == out_i); // R9
    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (st_i == ST_COUNT && sel_i && cnt_i != d_lat_i - 1'b1) |=> (st_i == ST_COUNT)); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st_i != ST_IDLE && $past(st_i) != ST_IDLE) |-> ($stable(d_lat_i) && $stable(w_lat_i))); // R11
endmodule

bind trig_delay_gen trig_delay_gen_chk #(
    .CNT_W(CNT_W), .PW_W(PW_W), .MAX_DELAY(MAX_DELAY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st_i(st_q), .cnt_i(cnt), .d_lat_i(d_lat),
    .w_lat_i(w_lat), .sel_i(sel), .acc_i(acc), .out_i(out_q), .fen_i(fen_q)
);

// File: tb/trig_delay_gen_test.sv
// Self-checking bench: directed corner cases plus seeded random runs.
module trig_delay_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic        trig_en = 1'b1;
    logic [14:0] delay_cfg = 15'd10;
    logic [13:0] div_cfg = 14'd1;
    logic [7:0]  width_cfg = 8'd1;
    logic        fine_en, delay_out;

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    int rises = 0, rise_cyc = 0, hi_len = 0, last_w = 0, mism = 0;
    logic prev_out = 1'b0;
    bit done = 0;

    trig_delay_gen uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_en(trig_en),
        .delay_cfg(delay_cfg), .div_cfg(div_cfg), .width_cfg(width_cfg),
        .fine_en(fine_en), .delay_out(delay_out)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Observe outputs mid-cycle: rise time, pulse width, output agreement.
    always @(negedge clk) begin
        if (delay_out !== fine_en) mism <= mism + 1;
        if (delay_out && !prev_out) begin
            rises <= rises + 1;
            rise_cyc <= cyc;
            hi_len <= 1;
        end else if (delay_out) begin
            hi_len <= hi_len + 1;
        end else if (prev_out) begin
            last_w <= hi_len;
        end
        prev_out <= delay_out;
    end

    function automatic int eff_d(int d);
        return (d == 0) ? 1 : ((d > 10000) ? 10000 : d);
    endfunction

    function automatic int eff_w(int w);
        return (w == 0) ? 1 : w;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig(output int t0);
        trig_in = 1'b1;
        t0 = cyc;
        tick(3);
        trig_in = 1'b0;
        tick(3);
    endtask

    task automatic set_cfg(int d, int w, int r);
        delay_cfg = 15'(d);
        width_cfg = 8'(w);
        div_cfg = 14'(r);
        tick(3);
    endtask

    // Send n triggers; only the last one should fire.
    task automatic run_case(string req, int d, int w, int r, int n);
        int t0, base, de, we;
        set_cfg(d, w, r);
        base = rises;
        de = eff_d(d);
        we = eff_w(w);
        for (int k = 0; k < n; k++) pulse_trig(t0);
        tick(de + we + 6);
        chk(rises == base + 1, req, rises - base, 1);
        chk(rise_cyc == t0 + de + 3, req, rise_cyc - t0, de + 3);
        chk(last_w == we, req, last_w, we);
        chk(mism == 0, "R9", mism, 0);
        mism = 0;
    endtask

    initial begin
        int t0, t1, t2, base;
        void'($urandom(32'd20240611));
        tick(5);
        chk(delay_out == 1'b0, "R1", delay_out, 0);
        chk(fine_en == 1'b0, "R1", fine_en, 0);
        rst_n = 1'b1;
        tick(2);
        chk(delay_out == 1'b0 && fine_en == 1'b0, "R1", delay_out, 0);

        run_case("R1", 10, 2, 3, 3);
        run_case("R4", 12, 1, 0, 1);
        run_case("R4", 9, 2, 4, 4);
        run_case("R5", 1, 1, 1, 1);
        run_case("R5", 2, 3, 1, 1);
        run_case("R5", 100, 5, 1, 1);
        run_case("R6", 0, 2, 1, 1);
        run_case("R6", 15000, 1, 1, 1);
        run_case("R6", 10000, 1, 1, 1);
        run_case("R7", 31, 2, 1, 1);
        run_case("R7", 32, 2, 1, 1);
        run_case("R7", 33, 2, 1, 1);
        run_case("R7", 1023, 2, 1, 1);
        run_case("R7", 1024, 2, 1, 1);
        run_case("R7", 1025, 2, 1, 1);
        run_case("R8", 6, 0, 1, 1);
        run_case("R8", 6, 255, 1, 1);

        // R3: disabled edges start nothing and do not advance the divider.
        set_cfg(20, 3, 1);
        base = rises;
        trig_en = 1'b0;
        pulse_trig(t0);
        tick(40);
        chk(rises == base, "R3", rises - base, 0);
        set_cfg(20, 3, 2);
        pulse_trig(t0);
        trig_en = 1'b1;
        pulse_trig(t1);
        tick(40);
        chk(rises == base, "R3", rises - base, 0);
        pulse_trig(t2);
        tick(40);
        chk(rises == base + 1, "R3", rises - base, 1);
        chk(rise_cyc == t2 + 23, "R3", rise_cyc - t2, 23);

        // R2: a long high level gives one event only.
        set_cfg(5, 2, 1);
        base = rises;
        trig_in = 1'b1;
        t0 = cyc;
        tick(60);
        trig_in = 1'b0;
        tick(10);
        chk(rises == base + 1, "R2", rises - base, 1);
        chk(rise_cyc == t0 + 8, "R2", rise_cyc - t0, 8);

        // R10: trigger during counting is dropped, delay undisturbed.
        set_cfg(100, 3, 1);
        base = rises;
        pulse_trig(t0);
        tick(14);
        pulse_trig(t1);
        tick(110);
        chk(rises == base + 1, "R10", rises - base, 1);
        chk(rise_cyc == t0 + 103, "R10", rise_cyc - t0, 103);

        // R10: trigger during the pulse is dropped.
        set_cfg(10, 40, 1);
        base = rises;
        pulse_trig(t0);
        tick(10);
        pulse_trig(t1);
        tick(70);
        chk(rises == base + 1, "R10", rises - base, 1);
        chk(last_w == 40, "R10", last_w, 40);

        // R10: a dropped trigger still advances the divider.
        set_cfg(60, 2, 2);
        base = rises;
        pulse_trig(t0);
        pulse_trig(t1);
        tick(10);
        pulse_trig(t2);
        tick(70);
        chk(rises == base + 1, "R10", rises - base, 1);
        chk(rise_cyc == t1 + 63, "R10", rise_cyc - t1, 63);
        pulse_trig(t2);
        tick(75);
        chk(rises == base + 2, "R10", rises - base, 2);
        chk(rise_cyc == t2 + 63, "R10", rise_cyc - t2, 63);

        // R11: settings written while busy wait for the next run.
        set_cfg(40, 4, 1);
        base = rises;
        pulse_trig(t0);
        tick(4);
        delay_cfg = 15'd7;
        width_cfg = 8'd9;
        tick(60);
        chk(rise_cyc == t0 + 43, "R11", rise_cyc - t0, 43);
        chk(last_w == 4, "R11", last_w, 4);
        pulse_trig(t1);
        tick(30);
        chk(rise_cyc == t1 + 10, "R11", rise_cyc - t1, 10);
        chk(last_w == 9, "R11", last_w, 9);
        chk(rises == base + 2, "R11", rises - base, 2);

        // Random delays, widths and ratios.
        for (int i = 0; i < 30; i++) begin
            int d, w, r;
            d = int'($urandom_range(1, 1100));
            w = int'($urandom_range(1, 16));
            r = int'($urandom_range(1, 3));
            run_case("R5", d, w, r, r);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule